// File: doc/BRIEF.md
# Three-Way Set-Associative Write-Back Data Cache

This block sits between the load/store port of a 32-bit processor and a simple word-wide memory port. It keeps 4 sets of 3 ways each, and each line holds 16 words of 32 bits. A request is taken while `ready_o` is high. The block then looks up the indexed set. On a hit it returns the addressed word one cycle later. On a miss it picks a victim, writes the victim back if it is dirty, refills the whole line, and then completes the access as if it had hit.

Stores are write-back and write-allocate. A store changes only the cached line, under control of its byte enables, and marks that line dirty. The memory sees the new data only when the line is later evicted. Because there are three ways, victim choice keeps a per-set age ordering rather than a binary pseudo-LRU tree. Only one request is outstanding at a time. A synchronous invalidate input drops the whole contents of the cache without writing anything back.

Top module: `sa_dcache`

## Requirements
- R1: Byte address fields: bits [31:8] are the tag, bits [7:6] pick the set, bits [5:2] pick the word within the line, and bits [1:0] are ignored. An access with the same tag but a different set, or with the same set but a different tag, does not hit the resident line.
- R2: A load that hits drives `rvalid_o` high for one cycle. That cycle comes one clock after the cycle in which the request was accepted. In it `hit_o` is 1 and `rdata_o` carries the addressed word.
- R3: A hit requires a valid way in the indexed set whose stored tag equals the address tag. At most one way of a set matches.
- R4: On a miss the line is fetched as 16 memory reads, from word 0 up to word 15 of the line base address. The response has `hit_o` = 0 and carries the refilled word. With the memory acknowledging every cycle, a clean miss responds 18 clocks after acceptance.
- R5: The victim on a miss is the lowest-numbered invalid way of the set. If every way is valid, the victim is the least recently used way. Every hit and every refill makes the way it touched the most recent.
- R6: A dirty victim is first written back as 16 memory writes, word 0 to word 15, at the address of the victim's own tag and set. The refill follows. A clean victim causes no memory write. A dirty miss responds 34 clocks after acceptance when memory acknowledges every cycle.
- R7: A store hit changes only the byte lanes whose `be_i` bit is set (bit n covers data bits 8n+7:8n). It marks the line dirty and performs no memory access. Its response carries the merged word with `hit_o` = 1.
- R8: A store miss allocates the line first, then merges the store data into it. The response has `hit_o` = 0, and a later load of that word hits and returns the merged value.
- R9: `ready_o` is low from the clock after acceptance until the response cycle, when it is high again. While `mem_req_o` is high without `mem_ack_i`, the memory request and its address stay unchanged.
- R10: `invalidate_i` high while the block is idle clears every valid and dirty bit at the next clock and writes nothing back. `ready_o` is low during that cycle, so no request is accepted.
- R11: After reset `ready_o` is 1, `rvalid_o` is 0, `mem_req_o` is 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor request, taken when ready_o is high |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data |
| be_i | input | 4 | Store byte enables |
| invalidate_i | input | 1 | Drop all lines, honoured when idle |
| ready_o | output | 1 | Block can accept a request this cycle |
| rvalid_o | output | 1 | One-cycle response strobe |
| hit_o | output | 1 | Response was a hit (1) or a miss (0) |
| rdata_o | output | 32 | Loaded word, or merged word for a store |
| mem_req_o | output | 1 | Memory word transfer requested |
| mem_we_o | output | 1 | Transfer is a write-back |
| mem_addr_o | output | 32 | Memory byte address of the word |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ack_i | input | 1 | Memory completes the current word |
| mem_rdata_i | input | 32 | Refill data, valid with mem_ack_i |

## Verification
The bench builds the block with its default geometry: 4 sets, 3 ways and 16-word lines. With three ways, the age ordering moves through non-power-of-two permutations, and directed sequences force a hit to reorder a full set before an eviction. Tags are kept below 16, so every line fits in a 1024-word memory model and lines from different sets collide in each set. One phase has memory acknowledge only every other cycle. That phase checks that requests are held while the memory stalls, and that dirty evictions interleave with refills.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL
  } state_e;
endpackage

// File: rtl/dcache_lru.sv
module dcache_lru #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 3,
  parameter int IDX_W    = 2,
  parameter int WAY_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [IDX_W-1:0] set_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] lru_way_o
);
  // age 0 = most recent, NUM_WAYS-1 = least recent
  logic [WAY_W-1:0] age_q [NUM_SETS][NUM_WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (clear_i) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (age_q[set_i][w] == WAY_W'(NUM_WAYS - 1)) lru_way_o = WAY_W'(w);
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [NUM_WAYS-1:0] oldest;
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign oldest[w] = (age_q[s][w] == WAY_W'(NUM_WAYS - 1));
    end
    assert_lru_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(oldest) == 1);
  end

  // touched way must no longer be the victim candidate of its set
  assert_touch_mru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && !clear_i) |=> (set_i != $past(set_i)) || (lru_way_o != $past(touch_way_i)));
endmodule

// File: rtl/dcache_tags.sv
module dcache_tags #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 3,
  parameter int TAG_W    = 24,
  parameter int IDX_W    = 2,
  parameter int WAY_W    = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic [IDX_W-1:0]               set_i,
  input  logic [TAG_W-1:0]               tag_i,
  input  logic                           fill_i,
  input  logic [WAY_W-1:0]               fill_way_i,
  input  logic                           mark_dirty_i,
  input  logic [WAY_W-1:0]               dirty_way_i,
  output logic                           hit_o,
  output logic [WAY_W-1:0]               hit_way_o,
  output logic [NUM_WAYS-1:0]            valid_o,
  output logic [NUM_WAYS-1:0]            dirty_o,
  output logic [NUM_WAYS-1:0][TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0] dirty_q [NUM_SETS];
  logic [NUM_WAYS-1:0] hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) tag_q[s][w] <= '0;
      end
    end else if (clear_i) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_i) begin
        tag_q[set_i][fill_way_i]   <= tag_i;
        valid_q[set_i][fill_way_i] <= 1'b1;
        dirty_q[set_i][fill_way_i] <= 1'b0;
      end
      if (mark_dirty_i) dirty_q[set_i][dirty_way_i] <= 1'b1;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign tag_o[w]   = tag_q[set_i][w];
    assign hit_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  assign valid_o = valid_q[set_i];
  assign dirty_o = dirty_q[set_i];
  assign hit_o   = |hit_vec;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end

  assert_hit_unique_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_dirty_on_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_dirty_i |-> valid_o[dirty_way_i]);
endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 3,
  parameter int LINE_WORDS = 16,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 2,
  parameter int WAY_W      = 2,
  parameter int WORD_W     = 4
) (
  input  logic                clk_i,
  input  logic [IDX_W-1:0]    set_i,
  input  logic [WAY_W-1:0]    rd_way_i,
  input  logic [WORD_W-1:0]   rd_word_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic                we_i,
  input  logic [WAY_W-1:0]    wr_way_i,
  input  logic [WORD_W-1:0]   wr_word_i,
  input  logic [DATA_W/8-1:0] wr_be_i,
  input  logic [DATA_W-1:0]   wr_data_i
);
  localparam int DEPTH  = NUM_SETS * NUM_WAYS * LINE_WORDS;
  localparam int A_W    = $clog2(DEPTH);
  localparam int BE_W   = DATA_W / 8;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [A_W-1:0]    rd_idx, wr_idx;

  assign rd_idx = A_W'((int'(set_i) * NUM_WAYS + int'(rd_way_i)) * LINE_WORDS + int'(rd_word_i));
  assign wr_idx = A_W'((int'(set_i) * NUM_WAYS + int'(wr_way_i)) * LINE_WORDS + int'(wr_word_i));
  assign rd_data_o = mem_q[rd_idx];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < BE_W; b++)
        if (wr_be_i[b]) mem_q[wr_idx][8*b +: 8] <= wr_data_i[8*b +: 8];
    end
  end
endmodule

// File: rtl/sa_dcache.sv
module sa_dcache
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 3,
  parameter int LINE_WORDS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic                invalidate_i,
  output logic                ready_o,
  output logic                rvalid_o,
  output logic                hit_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int BE_W   = DATA_W / 8;
  localparam int BYTE_W = $clog2(BE_W);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - BYTE_W;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);

  state_e                  state_q;
  logic [ADDR_W-1:BYTE_W]  addr_q;
  logic                    we_q, missed_q, rvalid_q, hit_q;
  logic [DATA_W-1:0]       wdata_q, rdata_q;
  logic [BE_W-1:0]         be_q;
  logic [WAY_W-1:0]        vic_q;
  logic [WORD_W-1:0]       cnt_q;

  logic [TAG_W-1:0]        req_tag;
  logic [IDX_W-1:0]        req_set;
  logic [WORD_W-1:0]       req_word;

  logic                    tag_hit;
  logic [WAY_W-1:0]        hit_way, lru_way, vic_d;
  logic [NUM_WAYS-1:0]     way_valid, way_dirty;
  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag;

  logic                    accept, inv_go, lookup_hit, fill_we, fill_last, wb_last;
  logic [DATA_W-1:0]       line_word, merged;

  assign req_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign req_set  = addr_q[BYTE_W+WORD_W +: IDX_W];
  assign req_word = addr_q[BYTE_W +: WORD_W];

  assign ready_o    = (state_q == ST_IDLE) && !invalidate_i;
  assign accept     = ready_o && req_i;
  assign inv_go     = (state_q == ST_IDLE) && invalidate_i;
  assign lookup_hit = (state_q == ST_LOOKUP) && tag_hit;
  assign fill_we    = (state_q == ST_FILL) && mem_ack_i;
  assign fill_last  = fill_we && (cnt_q == LAST_WORD);
  assign wb_last    = (state_q == ST_WBACK) && mem_ack_i && (cnt_q == LAST_WORD);

  dcache_tags #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (inv_go),
    .set_i       (req_set),
    .tag_i       (req_tag),
    .fill_i      (fill_last),
    .fill_way_i  (vic_q),
    .mark_dirty_i(lookup_hit && we_q),
    .dirty_way_i (hit_way),
    .hit_o       (tag_hit),
    .hit_way_o   (hit_way),
    .valid_o     (way_valid),
    .dirty_o     (way_dirty),
    .tag_o       (way_tag)
  );

  dcache_lru #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (inv_go),
    .set_i      (req_set),
    .touch_i    (lookup_hit || fill_last),
    .touch_way_i(lookup_hit ? hit_way : vic_q),
    .lru_way_o  (lru_way)
  );

  dcache_data #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .LINE_WORDS(LINE_WORDS),
    .DATA_W(DATA_W), .IDX_W(IDX_W), .WAY_W(WAY_W), .WORD_W(WORD_W)
  ) u_data (
    .clk_i    (clk_i),
    .set_i    (req_set),
    .rd_way_i ((state_q == ST_WBACK) ? vic_q : hit_way),
    .rd_word_i((state_q == ST_WBACK) ? cnt_q : req_word),
    .rd_data_o(line_word),
    .we_i     (fill_we || (lookup_hit && we_q)),
    .wr_way_i (fill_we ? vic_q : hit_way),
    .wr_word_i(fill_we ? cnt_q : req_word),
    .wr_be_i  (fill_we ? {BE_W{1'b1}} : be_q),
    .wr_data_i(fill_we ? mem_rdata_i : wdata_q)
  );

  // invalid ways first, lowest index wins; otherwise the oldest way
  always_comb begin
    logic found;
    found = 1'b0;
    vic_d = lru_way;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!found && !way_valid[w]) begin
        vic_d = WAY_W'(w);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BE_W; b++)
      merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : line_word[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      be_q     <= '0;
      missed_q <= 1'b0;
      vic_q    <= '0;
      cnt_q    <= '0;
      rvalid_q <= 1'b0;
      hit_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q   <= addr_i[ADDR_W-1:BYTE_W];
            we_q     <= we_i;
            wdata_q  <= wdata_i;
            be_q     <= be_i;
            missed_q <= 1'b0;
            state_q  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (tag_hit) begin
            rvalid_q <= 1'b1;
            hit_q    <= !missed_q;
            rdata_q  <= we_q ? merged : line_word;
            state_q  <= ST_IDLE;
          end else begin
            vic_q    <= vic_d;
            missed_q <= 1'b1;
            cnt_q    <= '0;
            state_q  <= (way_valid[vic_d] && way_dirty[vic_d]) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ack_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (wb_last) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (fill_last) state_q <= ST_LOOKUP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rvalid_o    = rvalid_q;
  assign hit_o       = hit_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WBACK);
  assign mem_wdata_o = line_word;
  assign mem_addr_o  = (state_q == ST_WBACK)
                     ? {way_tag[vic_q], req_set, cnt_q, {BYTE_W{1'b0}}}
                     : {req_tag, req_set, cnt_q, {BYTE_W{1'b0}}};

  assert_wb_dirty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (way_valid[vic_q] && way_dirty[vic_q]));

  assert_refill_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_last |=> tag_hit);

  assert_mem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_busy_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

  assert_inv_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_go |=> (way_valid == '0) && (way_dirty == '0));
endmodule

// File: tb/sa_dcache_test.sv
module sa_dcache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, inv = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0]  be = '0;
  logic        ready, rvalid, hit;
  logic [31:0] rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, failures = 0, wr_cnt = 0, cyc = 0;
  bit stall_en = 1'b0, done = 1'b0;

  logic [31:0] mem    [1024];
  logic [31:0] refmem [1024];
  int          mtag   [4][3];
  bit          mval   [4][3];
  bit          mdirty [4][3];
  int          mage   [4][3];
  logic [31:0] mdat   [4][3][16];

  always #2 clk = ~clk;

  sa_dcache uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .invalidate_i(inv), .ready_o(ready),
    .rvalid_o(rvalid), .hit_o(hit), .rdata_o(rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model: decides the ack for the coming edge
  always @(negedge clk) begin
    cyc++;
    mem_ack   = mem_req && (!stall_en || cyc[0]);
    mem_rdata = mem[mem_addr[11:2]];
    if (mem_ack && mem_we) begin
      mem[mem_addr[11:2]] = mem_wdata;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return {t[23:0], s[1:0], w[3:0], 2'b00};
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 3; w++) begin
        mval[s][w] = 0; mdirty[s][w] = 0; mage[s][w] = w; mtag[s][w] = 0;
      end
  endtask

  task automatic model_access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                              input logic [3:0] bmask, output bit eh,
                              output logic [31:0] er, output int ewr);
    int t, s, wi, hw, v, old;
    t = int'(a[31:8]); s = int'(a[7:6]); wi = int'(a[5:2]); hw = -1; ewr = 0;
    for (int w = 0; w < 3; w++) if (mval[s][w] && mtag[s][w] == t) hw = w;
    eh = (hw >= 0);
    if (!eh) begin
      v = -1;
      for (int w = 0; w < 3; w++) if (v < 0 && !mval[s][w]) v = w;
      if (v < 0) for (int w = 0; w < 3; w++) if (mage[s][w] == 2) v = w;
      if (mval[s][v] && mdirty[s][v]) begin
        for (int i = 0; i < 16; i++) refmem[(mtag[s][v]*64 + s*16 + i) % 1024] = mdat[s][v][i];
        ewr = 16;
      end
      for (int i = 0; i < 16; i++) mdat[s][v][i] = refmem[(t*64 + s*16 + i) % 1024];
      mtag[s][v] = t; mval[s][v] = 1; mdirty[s][v] = 0; hw = v;
    end
    old = mage[s][hw];
    for (int w = 0; w < 3; w++) if (mage[s][w] < old) mage[s][w]++;
    mage[s][hw] = 0;
    if (wr) begin
      for (int b = 0; b < 4; b++) if (bmask[b]) mdat[s][hw][wi][8*b +: 8] = wd[8*b +: 8];
      mdirty[s][hw] = 1;
    end
    er = mdat[s][hw][wi];
  endtask

  task automatic do_access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                           input logic [3:0] bmask, input bit chk_lat, input string r);
    bit eh, busy_ok;
    logic [31:0] er;
    int ewr, w0, lat, elat;
    model_access(wr, a, wd, bmask, eh, er, ewr);
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = wd; be = bmask;
    w0 = wr_cnt;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 0; busy_ok = 1'b1;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (rvalid) break;
      if (ready) busy_ok = 1'b0;
      if (lat > 300) break;
    end
    chk(busy_ok, "R9", "ready low while busy", 32'(busy_ok), 32'd1);
    chk(rvalid, r, "response seen", 32'(rvalid), 32'd1);
    chk(ready, "R9", "ready in response cycle", 32'(ready), 32'd1);
    chk(hit == eh, r, "hit flag", 32'(hit), 32'(eh));
    chk(rdata === er, r, "response data", rdata, er);
    chk(wr_cnt - w0 == ewr, r, "memory writes", 32'(wr_cnt - w0), 32'(ewr));
    if (chk_lat) begin
      elat = eh ? 1 : (ewr != 0 ? 34 : 18);
      chk(lat == elat, r, "latency", 32'(lat), 32'(elat));
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 32'd0, 32'd1);
      summary();
    end
  end

  initial begin
    logic [31:0] seed;
    int bad;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'h5a00_0000 + i * 32'h0001_0203;
      refmem[i] = mem[i];
    end
    model_reset();
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ready == 1'b1, "R11", "ready after reset", 32'(ready), 32'd1);
    chk(rvalid == 1'b0, "R11", "rvalid after reset", 32'(rvalid), 32'd0);
    chk(mem_req == 1'b0, "R11", "mem_req after reset", 32'(mem_req), 32'd0);

    do_access(0, mk(1, 0, 3), 0, 0, 1, "R4");   // cold miss
    do_access(0, mk(1, 0, 9), 0, 0, 1, "R2");   // same line hit
    do_access(0, mk(1, 0, 9) | 32'h3, 0, 0, 1, "R1"); // byte bits ignored
    do_access(0, mk(1, 1, 3), 0, 0, 1, "R1");   // other set misses
    do_access(0, mk(2, 0, 3), 0, 0, 1, "R1");   // other tag -> way 1
    do_access(0, mk(3, 0, 0), 0, 0, 1, "R5");   // way 2
    do_access(0, mk(1, 0, 1), 0, 0, 1, "R5");   // touch tag 1
    do_access(0, mk(4, 0, 2), 0, 0, 1, "R5");   // evicts tag 2
    do_access(0, mk(1, 0, 4), 0, 0, 1, "R5");
    do_access(0, mk(3, 0, 4), 0, 0, 1, "R5");
    do_access(0, mk(2, 0, 4), 0, 0, 1, "R5");   // miss again
    do_access(1, mk(1, 0, 5), 32'hdead_beef, 4'b0101, 1, "R7");
    do_access(0, mk(1, 0, 5), 0, 0, 1, "R7");
    do_access(0, mk(5, 0, 0), 0, 0, 1, "R6");
    do_access(0, mk(6, 0, 0), 0, 0, 1, "R6");
    do_access(0, mk(7, 0, 0), 0, 0, 1, "R6");
    do_access(1, mk(8, 2, 0), 32'h1234_5678, 4'b1111, 1, "R8");
    do_access(0, mk(8, 2, 0), 0, 0, 1, "R8");

    // stalled memory, mixed stream
    stall_en = 1'b1;
    seed = 32'h1357_9bdf;
    for (int n = 0; n < 250; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      do_access(seed[20], mk(int'(seed[27:24]) % 7, int'(seed[23:22]), int'(seed[19:16])),
                seed ^ 32'h0f0f_0f0f, seed[31:28], 0, "R3");
    end
    stall_en = 1'b0;

    // R10 invalidate drops dirty data
    do_access(1, mk(9, 3, 7), 32'hcafe_f00d, 4'b1111, 0, "R10");
    @(negedge clk);
    inv = 1'b1;
    #1 chk(ready == 1'b0, "R10", "ready during invalidate", 32'(ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    inv = 1'b0;
    model_reset();
    do_access(0, mk(9, 3, 7), 0, 0, 1, "R10");

    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refmem[i]) bad++;
    chk(bad == 0, "R6", "memory image mismatches", 32'(bad), 32'd0);
    done = 1'b1;
    summary();
  end
endmodule